// File: doc/BRIEF.md
# Hysteretic Memory Port Arbiter for Core and Trace Stores

This block shares one memory port between two requesters. The processor core issues ordinary loads and stores. A trace logger issues write-only records that it drains out of a small store queue. Each cycle the arbiter grants at most one of the two requesters and steers that requester's command onto the port through a multiplexer.

The core normally has precedence, so program traffic is not delayed by trace writes. When the trace path falls so far behind that it is holding up instruction commit, precedence moves to the trace queue. It stays there until the queue reports empty, and only then returns to the core. This hysteresis drains a backed-up trace queue in one burst instead of letting it oscillate on the edge of full.

A one-bit output shows which requester currently has precedence. A counter reports how many cycles have been spent with the trace queue in precedence.

Top module: `store_port_arbiter`

## Requirements
- R1: After reset, the precedence mode is core (`prio_log` = 0) and `log_prio_cycles` is 0.
- R2: When only `cpu_req_valid` is high, the port carries the core command: `mem_src` = 0, and `mem_we`, `mem_addr` and `mem_wdata` equal the core's fields. This holds in either mode.
- R3: When only `log_req_valid` is high, the trace request is selected in either mode: `mem_src` = 1, `mem_we` = 1, and the address and data come from the trace request.
- R4: When both requests are valid and the mode is core, the core is selected and `log_req_ready` is 0. The two ready outputs are never high together.
- R5: When both requests are valid and the mode is trace, the trace request is selected and `cpu_req_ready` is 0.
- R6: In core mode, `commit_stall_log` sampled high at a rising edge sets `prio_log` to 1 from that edge onward.
- R7: In trace mode, `prio_log` stays 1 while `log_q_empty` is sampled low, whatever the value of `commit_stall_log`. It returns to 0 at the first edge at which `log_q_empty` is sampled high.
- R8: Grants follow port readiness. When `mem_ready` is 0, both `cpu_req_ready` and `log_req_ready` are 0. When `mem_ready` is 1, the selected requester's ready is 1.
- R9: `log_prio_cycles` increments at every edge at which the mode is trace, holds while the mode is core, and saturates at its all-ones value.
- R10: `mem_valid` is high whenever at least one request is valid, and low when neither is.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| cpu_req_valid | input | 1 | Core request present |
| cpu_req_ready | output | 1 | Core request accepted this cycle |
| cpu_req_we | input | 1 | Core request is a store |
| cpu_req_addr | input | ADDR_W | Core request address |
| cpu_req_wdata | input | DATA_W | Core store data |
| log_req_valid | input | 1 | Trace store present |
| log_req_ready | output | 1 | Trace store accepted this cycle |
| log_req_addr | input | ADDR_W | Trace store address |
| log_req_wdata | input | DATA_W | Trace store data |
| log_q_empty | input | 1 | Trace store queue holds no entries |
| commit_stall_log | input | 1 | Commit is stalled because of the trace path |
| mem_ready | input | 1 | Memory port can accept a command |
| mem_valid | output | 1 | Command present on the port |
| mem_we | output | 1 | Port command is a write |
| mem_addr | output | ADDR_W | Port address |
| mem_wdata | output | DATA_W | Port write data |
| mem_src | output | 1 | Selected source: 0 core, 1 trace |
| prio_log | output | 1 | Current mode: 1 when the trace queue has precedence |
| log_prio_cycles | output | CNT_W | Saturating count of cycles spent in trace mode |

## Verification
The assertions are checked on every cycle. They cover:
- that a grant is suppressed whenever the port is not ready, and that the two grants are never given together;
- that the requester holding precedence wins a conflict;
- that the mode enters trace precedence on a stall and leaves it only on an empty queue;
- that the counter advances or holds according to the mode.

Some behaviour only the bench scenarios can show. The first is that the data, address and write flag reaching the port belong to the chosen source. The second is that a stall arriving while trace mode is already active has no visible effect. The third is that the counter settles at its all-ones value during a long drain. The bench shows these by comparing every port against a reference model over directed and random request mixes.

// File: rtl/sp_arb_pkg.sv
package sp_arb_pkg;

   typedef enum logic {
      PRIO_CORE = 1'b0,
      PRIO_LOG  = 1'b1
   } prio_mode_e;

   typedef enum logic {
      SRC_CORE = 1'b0,
      SRC_LOG  = 1'b1
   } port_src_e;

endpackage

// File: rtl/sp_prio_state.sv
module sp_prio_state
   import sp_arb_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       stall_from_log,
   input  logic       log_q_empty,
   output prio_mode_e mode_q
);

   prio_mode_e mode_d;

   always_comb begin
      mode_d = mode_q;
      unique case (mode_q)
         PRIO_CORE: if (stall_from_log) mode_d = PRIO_LOG;
         PRIO_LOG:  if (log_q_empty)    mode_d = PRIO_CORE;
         default:   mode_d = PRIO_CORE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) mode_q <= PRIO_CORE;
      else        mode_q <= mode_d;
   end

endmodule

// File: rtl/sp_port_select.sv
module sp_port_select
   import sp_arb_pkg::*;
#(
   parameter int ADDR_W     = 32,
   parameter int DATA_W     = 64,
   parameter bit AND_OR_MUX = 1'b1
) (
   input  prio_mode_e        mode,
   input  logic              cpu_valid,
   input  logic              cpu_we,
   input  logic [ADDR_W-1:0] cpu_addr,
   input  logic [DATA_W-1:0] cpu_wdata,
   input  logic              log_valid,
   input  logic [ADDR_W-1:0] log_addr,
   input  logic [DATA_W-1:0] log_wdata,
   input  logic              port_ready,
   output logic              cpu_grant,
   output logic              log_grant,
   output logic              port_valid,
   output logic              port_we,
   output logic [ADDR_W-1:0] port_addr,
   output logic [DATA_W-1:0] port_wdata,
   output port_src_e         port_src
);

   logic pick_log;
   logic pick_core;

   // The trace side wins when it is alone or when it holds precedence.
   assign pick_log  = log_valid & (~cpu_valid | (mode == PRIO_LOG));
   assign pick_core = ~pick_log;

   assign port_valid = cpu_valid | log_valid;
   assign cpu_grant  = port_ready & pick_core;
   assign log_grant  = port_ready & pick_log;
   assign port_src   = pick_log ? SRC_LOG : SRC_CORE;

   generate
      if (AND_OR_MUX) begin : g_andor
         logic sel_c;
         logic sel_l;
         assign sel_c      = pick_core & cpu_valid;
         assign sel_l      = pick_log;
         assign port_we    = (sel_c & cpu_we) | sel_l;
         assign port_addr  = ({ADDR_W{sel_c}} & cpu_addr)  | ({ADDR_W{sel_l}} & log_addr);
         assign port_wdata = ({DATA_W{sel_c}} & cpu_wdata) | ({DATA_W{sel_l}} & log_wdata);
      end else begin : g_ternary
         assign port_we    = pick_log ? 1'b1      : cpu_we;
         assign port_addr  = pick_log ? log_addr  : cpu_addr;
         assign port_wdata = pick_log ? log_wdata : cpu_wdata;
      end
   endgenerate

endmodule

// File: rtl/sp_dwell_counter.sv
module sp_dwell_counter #(
   parameter int CNT_W    = 16,
   parameter bit SATURATE = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   output logic [CNT_W-1:0] count
);

   localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

   logic bump;

   generate
      if (SATURATE) begin : g_sat
         assign bump = en & (count != CNT_MAX);
      end else begin : g_wrap
         assign bump = en;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    count <= '0;
      else if (bump) count <= count + 1'b1;
   end

endmodule

// File: rtl/store_port_arbiter.sv
module store_port_arbiter
   import sp_arb_pkg::*;
#(
   parameter int ADDR_W     = 32,
   parameter int DATA_W     = 64,
   parameter int CNT_W      = 16,
   parameter bit SATURATE   = 1'b1,
   parameter bit AND_OR_MUX = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cpu_req_valid,
   output logic              cpu_req_ready,
   input  logic              cpu_req_we,
   input  logic [ADDR_W-1:0] cpu_req_addr,
   input  logic [DATA_W-1:0] cpu_req_wdata,
   input  logic              log_req_valid,
   output logic              log_req_ready,
   input  logic [ADDR_W-1:0] log_req_addr,
   input  logic [DATA_W-1:0] log_req_wdata,
   input  logic              log_q_empty,
   input  logic              commit_stall_log,
   input  logic              mem_ready,
   output logic              mem_valid,
   output logic              mem_we,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [DATA_W-1:0] mem_wdata,
   output logic              mem_src,
   output logic              prio_log,
   output logic [CNT_W-1:0]  log_prio_cycles
);

   generate
      if (ADDR_W < 1) begin : g_bad_addr
         $error("store_port_arbiter: ADDR_W must be at least 1");
      end
      if (DATA_W < 1) begin : g_bad_data
         $error("store_port_arbiter: DATA_W must be at least 1");
      end
      if (CNT_W < 2 || CNT_W > 48) begin : g_bad_cnt
         $error("store_port_arbiter: CNT_W must lie in 2..48");
      end
   endgenerate

   prio_mode_e mode;
   port_src_e  src;

   sp_prio_state u_state (
      .clk            (clk),
      .rst_n          (rst_n),
      .stall_from_log (commit_stall_log),
      .log_q_empty    (log_q_empty),
      .mode_q         (mode)
   );

   sp_port_select #(
      .ADDR_W     (ADDR_W),
      .DATA_W     (DATA_W),
      .AND_OR_MUX (AND_OR_MUX)
   ) u_select (
      .mode       (mode),
      .cpu_valid  (cpu_req_valid),
      .cpu_we     (cpu_req_we),
      .cpu_addr   (cpu_req_addr),
      .cpu_wdata  (cpu_req_wdata),
      .log_valid  (log_req_valid),
      .log_addr   (log_req_addr),
      .log_wdata  (log_req_wdata),
      .port_ready (mem_ready),
      .cpu_grant  (cpu_req_ready),
      .log_grant  (log_req_ready),
      .port_valid (mem_valid),
      .port_we    (mem_we),
      .port_addr  (mem_addr),
      .port_wdata (mem_wdata),
      .port_src   (src)
   );

   sp_dwell_counter #(
      .CNT_W    (CNT_W),
      .SATURATE (SATURATE)
   ) u_dwell (
      .clk   (clk),
      .rst_n (rst_n),
      .en    (mode == PRIO_LOG),
      .count (log_prio_cycles)
   );

   assign prio_log = (mode == PRIO_LOG);
   assign mem_src  = (src == SRC_LOG);

endmodule

// File: rtl/sp_arb_checker.sv
module sp_arb_checker #(
   parameter int CNT_W = 16
) (
   input logic             clk,
   input logic             rst_n,
   input logic             cpu_req_valid,
   input logic             cpu_req_ready,
   input logic             log_req_valid,
   input logic             log_req_ready,
   input logic             log_q_empty,
   input logic             commit_stall_log,
   input logic             mem_ready,
   input logic             mem_valid,
   input logic             prio_log,
   input logic [CNT_W-1:0] log_prio_cycles
);

   localparam logic [CNT_W-1:0] CNT_TOP = {CNT_W{1'b1}};

   p_no_grant_unready_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !mem_ready |-> (!cpu_req_ready && !log_req_ready));

   p_single_grant_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !(cpu_req_ready && log_req_ready));

   p_core_wins_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_req_valid && log_req_valid && !prio_log && mem_ready) |-> (cpu_req_ready && !log_req_ready));

   p_log_wins_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_req_valid && log_req_valid && prio_log && mem_ready) |-> (log_req_ready && !cpu_req_ready));

   p_lone_log_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (log_req_valid && !cpu_req_valid && mem_ready) |-> log_req_ready);

   p_enter_log_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (!prio_log && commit_stall_log) |=> prio_log);

   p_hold_log_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (prio_log && !log_q_empty) |=> prio_log);

   p_leave_log_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (prio_log && log_q_empty) |=> !prio_log);

   p_count_step_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (prio_log && log_prio_cycles != CNT_TOP) |=> (log_prio_cycles == $past(log_prio_cycles) + 1'b1));

   p_count_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !prio_log |=> $stable(log_prio_cycles));

   p_port_valid_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_req_valid || log_req_valid) |-> mem_valid);

endmodule

bind store_port_arbiter sp_arb_checker #(.CNT_W(CNT_W)) u_sp_arb_checker (
   .clk              (clk),
   .rst_n            (rst_n),
   .cpu_req_valid    (cpu_req_valid),
   .cpu_req_ready    (cpu_req_ready),
   .log_req_valid    (log_req_valid),
   .log_req_ready    (log_req_ready),
   .log_q_empty      (log_q_empty),
   .commit_stall_log (commit_stall_log),
   .mem_ready        (mem_ready),
   .mem_valid        (mem_valid),
   .prio_log         (prio_log),
   .log_prio_cycles  (log_prio_cycles)
);

// File: tb/store_port_arbiter_tb.sv
`timescale 1ns/1ps
module store_port_arbiter_tb_top;

   localparam int AW = 16;
   localparam int DW = 32;
   localparam int CW = 4;
   localparam logic [CW-1:0] CMAX = {CW{1'b1}};

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          cpu_req_valid = 0, cpu_req_we = 0;
   logic [AW-1:0] cpu_req_addr = '0;
   logic [DW-1:0] cpu_req_wdata = '0;
   logic          log_req_valid = 0;
   logic [AW-1:0] log_req_addr = '0;
   logic [DW-1:0] log_req_wdata = '0;
   logic          log_q_empty = 1, commit_stall_log = 0, mem_ready = 1;
   logic          cpu_req_ready, log_req_ready, mem_valid, mem_we, mem_src, prio_log;
   logic [AW-1:0] mem_addr;
   logic [DW-1:0] mem_wdata;
   logic [CW-1:0] log_prio_cycles;

   int n_chk = 0;
   int n_bad = 0;
   bit done  = 0;

   logic          m_mode = 0;
   logic [CW-1:0] m_cnt  = '0;

   always #5 clk = ~clk;

   store_port_arbiter #(.ADDR_W(AW), .DATA_W(DW), .CNT_W(CW)) dut_i (.*);

   task automatic chk(input bit ok, input string req, input longint act, input longint exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic logic exp_pick_log(input logic cv, input logic lv, input logic md);
      return lv & (~cv | md);
   endfunction

   function automatic string sel_tag(input logic cv, input logic lv, input logic md);
      if (cv && !lv) return "R2";
      if (lv && !cv) return "R3";
      if (!md)       return "R4";
      return "R5";
   endfunction

   // Called just after a falling edge: drive, check, step the model at the rising edge.
   task automatic cycle(input logic cv, input logic cw, input logic [AW-1:0] ca, input logic [DW-1:0] cd,
                        input logic lv, input logic [AW-1:0] la, input logic [DW-1:0] ld,
                        input logic le, input logic cs, input logic mr);
      logic  pl;
      string tg;
      cpu_req_valid = cv; cpu_req_we = cw; cpu_req_addr = ca; cpu_req_wdata = cd;
      log_req_valid = lv; log_req_addr = la; log_req_wdata = ld;
      log_q_empty = le; commit_stall_log = cs; mem_ready = mr;
      #1;
      pl = exp_pick_log(cv, lv, m_mode);
      tg = sel_tag(cv, lv, m_mode);
      chk(prio_log === m_mode, "R6/R7 mode", prio_log, m_mode);
      chk(log_prio_cycles === m_cnt, "R9 count", log_prio_cycles, m_cnt);
      chk(mem_valid === (cv | lv), "R10 valid", mem_valid, cv | lv);
      chk(cpu_req_ready === (mr & ~pl), mr ? tg : "R8", cpu_req_ready, mr & ~pl);
      chk(log_req_ready === (mr & pl), mr ? tg : "R8", log_req_ready, mr & pl);
      if (cv || lv) begin
         chk(mem_src === pl, tg, mem_src, pl);
         chk(mem_we === (pl ? 1'b1 : cw), tg, mem_we, pl ? 1'b1 : cw);
         chk(mem_addr === (pl ? la : ca), tg, mem_addr, pl ? la : ca);
         chk(mem_wdata === (pl ? ld : cd), tg, mem_wdata, pl ? ld : cd);
      end
      @(posedge clk);
      if (m_mode && m_cnt != CMAX) m_cnt = m_cnt + 1'b1;
      m_mode = m_mode ? ~le : cs;
      @(negedge clk);
   endtask

   initial begin
      #(200000 * 10);
      if (!done) begin
         n_bad++;
         n_chk++;
         $display("FAIL watchdog expired");
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd1234));
      repeat (3) @(negedge clk);
      // R1: reset values
      chk(prio_log === 1'b0, "R1 mode", prio_log, 0);
      chk(log_prio_cycles === '0, "R1 count", log_prio_cycles, 0);
      rst_n = 1'b1;
      @(negedge clk);

      // R2: core alone, read then write
      cycle(1, 0, 16'h1000, 32'h0, 0, 16'h0, 32'h0, 1, 0, 1);
      cycle(1, 1, 16'h1004, 32'hCAFE0001, 0, 16'h0, 32'h0, 1, 0, 1);
      // R3: trace alone in core mode
      cycle(0, 0, 16'h0, 32'h0, 1, 16'h8000, 32'hAAAA5555, 0, 0, 1);
      // R4: conflict in core mode
      cycle(1, 0, 16'h2000, 32'h1, 1, 16'h8004, 32'h2, 0, 0, 1);
      // R6: stall flips mode
      cycle(1, 1, 16'h2004, 32'h3, 1, 16'h8008, 32'h4, 0, 1, 1);
      // R5: conflict in trace mode
      cycle(1, 1, 16'h2008, 32'h5, 1, 16'h800C, 32'h6, 0, 0, 1);
      // R7: a stall while already in trace mode, queue not empty: mode stays
      cycle(1, 0, 16'h200C, 32'h7, 1, 16'h8010, 32'h8, 0, 1, 1);
      // R2: core alone while trace mode is active
      cycle(1, 1, 16'h2010, 32'h9, 0, 16'h0, 32'h0, 0, 0, 1);
      // R8: port not ready
      cycle(1, 1, 16'h2014, 32'hA, 1, 16'h8014, 32'hB, 0, 0, 0);
      // R9: long drain saturates the counter
      for (int i = 0; i < 20; i++)
         cycle(1, 0, 16'h3000, 32'h0, 1, AW'(16'h9000 + i), DW'(i), 0, 0, 1);
      // R7: empty queue returns to core mode
      cycle(1, 0, 16'h3004, 32'h0, 1, 16'h9100, 32'h1, 1, 0, 1);
      cycle(1, 0, 16'h3008, 32'h0, 1, 16'h9104, 32'h2, 1, 0, 1);
      // R10: idle port
      cycle(0, 0, 16'h0, 32'h0, 0, 16'h0, 32'h0, 1, 0, 1);

      // Random mix
      for (int i = 0; i < 3000; i++) begin
         cycle($urandom_range(0, 1), $urandom_range(0, 1), AW'($urandom), DW'($urandom),
               $urandom_range(0, 1), AW'($urandom), DW'($urandom),
               ($urandom_range(0, 7) == 0), ($urandom_range(0, 9) == 0),
               ($urandom_range(0, 3) != 0));
      end

      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

endmodule